// File: doc/BRIEF.md
# Random-Access Scan Cell Array

This block holds a bank of state flip-flops that a tester can read and write one at a time, by index, the way a small RAM is accessed, instead of shifting them through a serial chain. A short address register is filled one bit at a time on its own address clock. A decoder turns the stored index into a single select line. While the test-mode input is high, the selected flip-flop takes the broadcast scan data bit on the next rising edge of the main clock, and every other flip-flop keeps its value. The select line also places the selected flip-flop's state on the single scan output.

While the test-mode input is low, the bank behaves as ordinary functional state: every flip-flop loads its functional data input on each clock. A test procedure can therefore set up any state, change exactly one bit for a single-input-change delay test, run functional cycles, and read the captured state back bit by bit, without disturbing the bits it does not address.

Top module: `ras_cell_array`

## Requirements
- R1: While `rst_n` is low, every cell and the address register are cleared to 0; after release, `func_q` reads 0 and `scan_out` reads 0.
- R2: On each rising edge of `addr_clk`, the address register shifts left by one place and `addr_bit` enters at bit 0, so an index is sent most significant bit first, taking ADDR_W pulses.
- R3: The address register changes only on `addr_clk`; rising edges of `clk` in either mode leave the selected index unchanged.
- R4: With `test_mode` = 1 (scan) and an index below NUM_CELLS, the cell with that index loads `scan_in` on the rising edge of `clk`.
- R5: With `test_mode` = 1, every cell whose index differs from the address register keeps its value on `clk`, so a scan clock changes at most one bit of `func_q`, whatever `func_d` holds.
- R6: With `test_mode` = 0 (functional), every cell loads its own bit of `func_d` on the rising edge of `clk`, regardless of the address register and `scan_in`.
- R7: `scan_out` equals the current state of the cell selected by the address register, with no clock between them.
- R8: An index of NUM_CELLS or above selects no cell: a scan clock changes no bit and `scan_out` reads 0.
- R9: `func_q[i]` always presents the state of cell i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, for both functional capture and scan writes |
| rst_n | input | 1 | Asynchronous active-low reset for cells and address register |
| test_mode | input | 1 | 1 = scan (write the selected cell only), 0 = functional capture |
| scan_in | input | 1 | Scan data bit offered to every cell |
| scan_out | output | 1 | State of the selected cell, 0 when the index is out of range |
| addr_clk | input | 1 | Clock of the serial address register |
| addr_bit | input | 1 | Serial address data, most significant bit first |
| func_d | input | NUM_CELLS | Functional next-state inputs, one per cell |
| func_q | output | NUM_CELLS | Cell states, one per cell |

## Verification
The hardest situation to reach is a scan clock where the single written bit is the only difference from the previous state, proven for every cell position, every stored pattern and every unused index, because the address travels on a second clock and each index costs several serial pulses. The bench loads every one of the 64 patterns of a six-cell array through functional capture, then walks all eight indices, loading each serially while functional clocks hold the state, and writes the complement of the addressed bit with `func_d` forced to the opposite pattern. Each step compares the whole state vector and the scan output against a model, so a wrong shift order, a leaking neighbour or a write through an unused index shows up as a changed bit elsewhere.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;

    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_SCAN = 1'b1
    } ras_mode_e;

    // Index width for a bank of n cells; never below one bit.
    function automatic int unsigned index_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ras_addr_shreg.sv
`timescale 1ns/1ps
module ras_addr_shreg #(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              addr_clk,
    input  logic              rst_n,
    input  logic              shift_bit,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } areg_t;

    areg_t st_d, st_q;

    // Most significant bit arrives first: shift toward the top.
    always_comb begin
        st_d      = st_q;
        st_d.addr = (st_q.addr << 1) | ADDR_W'(shift_bit);
    end

    always_ff @(posedge addr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;

endmodule

// File: rtl/ras_addr_decode.sv
`timescale 1ns/1ps
module ras_addr_decode #(
    parameter int unsigned NUM_CELLS = 6,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_CELLS-1:0] sel_o
);

    // One comparator per cell; indices past the bank match nothing.
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_sel
        assign sel_o[i] = (addr_i == ADDR_W'(i));
    end

endmodule

// File: rtl/ras_cell.sv
`timescale 1ns/1ps
module ras_cell
    import ras_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ras_mode_e mode_i,
    input  logic      sel_i,
    input  logic      scan_d_i,
    input  logic      func_d_i,
    output logic      q_o
);

    typedef struct packed {
        logic q;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_i == MODE_FUNC) begin
            st_d.q = func_d_i;
        end else if (sel_i) begin
            st_d.q = scan_d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/ras_readout.sv
`timescale 1ns/1ps
module ras_readout #(
    parameter int unsigned NUM_CELLS = 6
) (
    input  logic [NUM_CELLS-1:0] sel_i,
    input  logic [NUM_CELLS-1:0] q_i,
    output logic                 bit_o
);

    // AND-OR mux: a select vector with no bit set yields 0.
    logic [NUM_CELLS-1:0] gated;

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_gate
        assign gated[i] = sel_i[i] & q_i[i];
    end

    assign bit_o = |gated;

endmodule

// File: rtl/ras_cell_array.sv
`timescale 1ns/1ps
module ras_cell_array
    import ras_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_mode,
    input  logic                 scan_in,
    output logic                 scan_out,
    input  logic                 addr_clk,
    input  logic                 addr_bit,
    input  logic [NUM_CELLS-1:0] func_d,
    output logic [NUM_CELLS-1:0] func_q
);

    localparam int unsigned ADDR_W = index_width(NUM_CELLS);

    logic [ADDR_W-1:0]    addr_cur;
    logic [NUM_CELLS-1:0] sel;
    ras_mode_e            mode;

    assign mode = test_mode ? MODE_SCAN : MODE_FUNC;

    ras_addr_shreg #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .addr_clk  (addr_clk),
        .rst_n     (rst_n),
        .shift_bit (addr_bit),
        .addr_o    (addr_cur)
    );

    ras_addr_decode #(
        .NUM_CELLS (NUM_CELLS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr_i (addr_cur),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        ras_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode),
            .sel_i    (sel[i]),
            .scan_d_i (scan_in),
            .func_d_i (func_d[i]),
            .q_o      (func_q[i])
        );
    end

    ras_readout #(
        .NUM_CELLS (NUM_CELLS)
    ) u_rd (
        .sel_i (sel),
        .q_i   (func_q),
        .bit_o (scan_out)
    );

endmodule

// File: rtl/ras_array_checker.sv
`timescale 1ns/1ps
module ras_array_checker #(
    parameter int unsigned NUM_CELLS = 6,
    parameter int unsigned ADDR_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 test_mode,
    input logic                 scan_in,
    input logic                 scan_out,
    input logic                 addr_clk,
    input logic                 addr_bit,
    input logic [NUM_CELLS-1:0] func_d,
    input logic [NUM_CELLS-1:0] func_q,
    input logic [ADDR_W-1:0]    addr
);

    localparam int unsigned SPAN = 1 << ADDR_W;

    logic [SPAN-1:0] q_ext;
    logic            in_range;

    assign q_ext    = SPAN'(func_q);
    assign in_range = (32'(addr) < NUM_CELLS);

    AST_FUNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> func_q == $past(func_d)); // R6

    AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> $countones(func_q ^ $past(func_q)) <= 1); // R5

    AST_SCAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && in_range) |=> q_ext[$past(addr)] == $past(scan_in)); // R4

    AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !in_range) |=> $stable(func_q)); // R8

    AST_READ_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> !scan_out); // R8

    AST_READ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> scan_out == q_ext[addr]); // R7

    AST_ADDR_ENTRY: assert property (@(posedge addr_clk) disable iff (!rst_n)
        1'b1 |=> addr[0] == $past(addr_bit)); // R2

endmodule

bind ras_cell_array ras_array_checker #(
    .NUM_CELLS (NUM_CELLS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .scan_out  (scan_out),
    .addr_clk  (addr_clk),
    .addr_bit  (addr_bit),
    .func_d    (func_d),
    .func_q    (func_q),
    .addr      (addr_cur)
);

// File: tb/test_ras_cell_array.sv
`timescale 1ns/1ps
module test_ras_cell_array;

    localparam int N  = 6;
    localparam int AW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic         scan_in = 1'b0;
    logic         addr_clk = 1'b0;
    logic         addr_bit = 1'b0;
    logic [N-1:0] func_d = '0;
    logic         scan_out;
    logic [N-1:0] func_q;

    int vectors = 0;
    int miscompares = 0;

    logic [N-1:0] model;

    ras_cell_array #(
        .NUM_CELLS (N)
    ) i_ras_cell_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .scan_in   (scan_in),
        .scan_out  (scan_out),
        .addr_clk  (addr_clk),
        .addr_bit  (addr_bit),
        .func_d    (func_d),
        .func_q    (func_q)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs change at the falling edge; results are read one falling edge later.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One address bit per clk period, pulsed while clk is low; cells are held
    // by functional capture of their own value (R3: clk must not move the index).
    task automatic load_addr(input int a);
        test_mode = 1'b0;
        func_d    = model;
        for (int b = AW - 1; b >= 0; b--) begin
            addr_bit = a[b];
            #0.5 addr_clk = 1'b1;
            #1.0 addr_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog expired");
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [N-1:0] expv;
        logic         sin;
        model = '0;
        repeat (3) @(negedge clk);
        chk("R1 state in reset", 32'(func_q), 32'h0);
        chk("R1 scan_out in reset", 32'(scan_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after reset", 32'(func_q), 32'h0);
        chk("R1 scan_out after reset", 32'(scan_out), 32'h0);

        for (int p = 0; p < (1 << N); p++) begin
            test_mode = 1'b0;
            func_d    = N'(p);
            scan_in   = ~scan_in;
            tick();
            model = N'(p);
            chk("R6 R9 functional capture", 32'(func_q), 32'(p));

            for (int a = 0; a < (1 << AW); a++) begin
                load_addr(a);
                // R2 R3 R7 R8: the index is the serial value, unchanged by clk
                chk("R7 R8 read before write", 32'(scan_out),
                    (a < N) ? 32'(model[a]) : 32'h0);
                chk("R3 state held during address load", 32'(func_q), 32'(model));

                sin       = (a < N) ? ~model[a] : p[0];
                test_mode = 1'b1;
                scan_in   = sin;
                func_d    = ~model;
                tick();
                expv = model;
                if (a < N) expv[a] = sin;
                chk((a < N) ? "R2 R4 write addressed cell" : "R8 no write out of range",
                    32'(func_q), 32'(expv));
                chk("R5 one bit changes", 32'($countones(func_q ^ model) <= 1), 32'h1);
                chk("R7 R8 read after write", 32'(scan_out),
                    (a < N) ? 32'(sin) : 32'h0);
                model = expv;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule